// File: doc/BRIEF.md
# Latched Event and Interrupt Controller

This block collects single-cycle event pulses from a group of per-port monitors (power changes, detection results, current-limit faults, startup failures and supply faults) and holds each pulse as a sticky bit in one of several event registers. Software reads those registers through a simple read strobe and address. Every event register sits at a pair of addresses. The even address returns the contents and leaves them alone. The odd address returns the contents and wipes them in the same access.

A summary register at address 0x00 has one bit per event register, and each bit is the OR of that register's bits. It is not stored: it follows the event registers directly. A writable mask at address 0x01 selects which summary bits may pull the active-low interrupt output. A single-cycle software reset input empties every event register and returns the mask to its default. Supply faults are only recorded here. They have no path that shuts any port off.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After the synchronous active-low reset, every event register reads 0x00, the summary reads 0x00, the mask reads 0xF8, `rd_data` is 0x00 and `irq_n` is 1.
- R2: A 1 on bit b of event slice k (`evt_i[8k+b]`) for one cycle sets bit b of event register k. The bit then stays set until it is cleared. Register k is 0 = power change, 1 = detection, 2 = current limit, 3 = startup failure, 4 = supply.
- R3: A read of address 0x02+2k returns event register k and leaves its contents unchanged.
- R4: A read of address 0x03+2k returns event register k and then clears it.
- R5: An event pulse that arrives in the same cycle as a clearing read of its register stays set after that read. It is not part of the data that the read returns.
- R6: A read of address 0x00 returns the summary. Bit 7 is the OR of the supply register, bit 6 the OR of the startup-failure register, bit 5 the OR of the current-limit register, bit 4 the OR of the detection register and bit 3 the OR of the power-change register. Bits 2:0 read 0.
- R7: A pulse on `mask_wr` loads `mask_wdata` into the mask. A read of address 0x01 returns the mask.
- R8: `irq_n` is 0 exactly when some summary bit is 1 and its mask bit is 1. It follows the event registers and the mask with no added delay.
- R9: A pulse on `sw_rst` clears all event registers and restores the mask to 0xF8. This takes precedence over event pulses and mask writes in the same cycle.
- R10: A supply event changes only the supply register and summary bit 7. No other event register changes.
- R11: Reads of addresses 0x0C and above return 0x00 and clear nothing.
- R12: `rd_data` takes the addressed value on the clock edge that samples `rd_en`. It holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_rst | input | 1 | Single-cycle software reset pulse |
| evt_i | input | 40 | Event pulses, 8 bits per event register, register k in bits [8k+7:8k] |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A new event pulse and a clearing read of the same register can land on the same clock edge. The bench provokes this by latching one bit of the current-limit register and then, in a single cycle, issuing the clearing read while pulsing a different bit of that register. It judges the result in two steps. The returned byte must hold only the old bit. A following clearing read must return only the new bit, with `irq_n` still low between the two reads. A software reset that coincides with a supply event pulse is tested the same way. Nothing may survive it.

// File: rtl/evt_irq_pkg.sv
// Package: shared types of the event and interrupt controller.
// Assumes: nothing beyond the users choosing a matching data width.
package evt_irq_pkg;

    // Source that a decoded read address selects.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SUM  = 2'd1,
        SRC_MASK = 2'd2,
        SRC_EVT  = 2'd3
    } rd_src_e;

endpackage

// File: rtl/evt_irq_latch.sv
// Module: evt_irq_latch
// One sticky event register. Pulses on set_i OR into the stored bits.
// clr_i empties the register, but bits set in the same cycle still land.
// sw_rst_i wipes everything and beats set_i.
// Assumes: set_i bits are single-cycle pulses from the event sources.
module evt_irq_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] set_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] keep;

    // Old bits survive only when no clearing read hits this register.
    always_comb begin
        keep = clr_i ? '0 : q_o;
    end

    // Sticky storage with software reset taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (sw_rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= keep | set_i;
        end
    end

endmodule

// File: rtl/evt_irq_dec.sv
// Module: evt_irq_dec
// Read address decoder. Finds the source of a read and, for event
// registers, the register index. It also raises a one-hot clear when the
// odd address of a pair is read.
// Assumes: event pairs start at EVT_BASE (even) and sit above the summary
// and mask addresses.
module evt_irq_dec
    import evt_irq_pkg::*;
#(
    parameter int NUM_EVT  = 5,
    parameter int ADDR_W   = 8,
    parameter int EVT_BASE = 2,
    parameter int SUM_ADDR = 0,
    parameter int MSK_ADDR = 1,
    parameter int IDX_W    = 3
) (
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output rd_src_e            src_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_EVT-1:0] clr_o
);

    localparam int PAIR_W = ADDR_W - 1;

    logic [ADDR_W-1:0] off;
    logic [PAIR_W-1:0] pair;
    logic              evt_hit;
    logic              cor_hit;

    // Offset into the event area, split into pair number and clear flag.
    always_comb begin
        off     = addr_i - ADDR_W'(EVT_BASE);
        pair    = off[ADDR_W-1:1];
        evt_hit = (addr_i >= ADDR_W'(EVT_BASE)) && (pair < PAIR_W'(NUM_EVT));
        cor_hit = evt_hit && off[0];
        idx_o   = pair[IDX_W-1:0];
    end

    // Pick the read source from the address.
    always_comb begin
        if (addr_i == ADDR_W'(SUM_ADDR)) begin
            src_o = SRC_SUM;
        end else if (addr_i == ADDR_W'(MSK_ADDR)) begin
            src_o = SRC_MASK;
        end else if (evt_hit) begin
            src_o = SRC_EVT;
        end else begin
            src_o = SRC_NONE;
        end
    end

    // One clear line per event register, raised only on a clearing read.
    always_comb begin
        for (int k = 0; k < NUM_EVT; k++) begin
            clr_o[k] = rd_en_i && cor_hit && (pair == PAIR_W'(k));
        end
    end

endmodule

// File: rtl/evt_irq_summary.sv
// Module: evt_irq_summary
// Builds the summary byte from the event registers. Register k drives
// summary bit DATA_W-NUM_EVT+k and the lowest bits stay 0. This module
// also holds the interrupt mask and drives the active-low interrupt.
// Assumes: NUM_EVT <= DATA_W.
module evt_irq_summary #(
    parameter int              NUM_EVT  = 5,
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] MASK_RST = 8'hF8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sw_rst_i,
    input  logic                           mask_wr_i,
    input  logic [DATA_W-1:0]              mask_wdata_i,
    input  logic [NUM_EVT-1:0][DATA_W-1:0] evt_q_i,
    output logic [DATA_W-1:0]              summary_o,
    output logic [DATA_W-1:0]              mask_q_o,
    output logic                           irq_n_o
);

    localparam int LOW_BITS = DATA_W - NUM_EVT;

    // Summary bits: an OR per event register, zeros below.
    for (genvar b = 0; b < DATA_W; b++) begin : g_sum
        if (b >= LOW_BITS) begin : g_live
            assign summary_o[b] = |evt_q_i[b-LOW_BITS];
        end else begin : g_zero
            assign summary_o[b] = 1'b0;
        end
    end

    // Mask register, restored by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q_o <= MASK_RST;
        end else if (sw_rst_i) begin
            mask_q_o <= MASK_RST;
        end else if (mask_wr_i) begin
            mask_q_o <= mask_wdata_i;
        end
    end

    // Interrupt pulls low when any enabled summary bit is set.
    always_comb begin
        irq_n_o = ~|(summary_o & mask_q_o);
    end

endmodule

// File: rtl/evt_irq_rdmux.sv
// Module: evt_irq_rdmux
// Registered read data. The selected value is captured on the edge that
// samples the strobe and is held until the next strobe. On a clearing
// read it captures the value from before the clear.
// Assumes: idx_i is in range whenever src_i is SRC_EVT.
module evt_irq_rdmux
    import evt_irq_pkg::*;
#(
    parameter int NUM_EVT = 5,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en_i,
    input  rd_src_e                        src_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [NUM_EVT-1:0][DATA_W-1:0] evt_q_i,
    input  logic [DATA_W-1:0]              summary_i,
    input  logic [DATA_W-1:0]              mask_i,
    output logic [DATA_W-1:0]              rd_data_o
);

    logic [DATA_W-1:0] sel;

    // Choose the byte that the current address names.
    always_comb begin
        sel = '0;
        unique case (src_i)
            SRC_SUM:  sel = summary_i;
            SRC_MASK: sel = mask_i;
            SRC_EVT: begin
                for (int k = 0; k < NUM_EVT; k++) begin
                    if (idx_i == IDX_W'(k)) begin
                        sel = evt_q_i[k];
                    end
                end
            end
            default:  sel = '0;
        endcase
    end

    // Capture on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= sel;
        end
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: evt_irq_ctrl (top)
// Latched event and interrupt controller. NUM_EVT sticky event registers
// each sit at a read-only and a clear-on-read address. A summary and a
// mask sit at fixed addresses, and an active-low interrupt is driven.
// Assumes: event inputs are single-cycle pulses; sw_rst is a one-cycle
// pulse; reads and mask writes are one-cycle strobes.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int                NUM_EVT  = 5,
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 8,
    parameter int                EVT_BASE = 2,
    parameter logic [DATA_W-1:0] MASK_RST = 8'hF8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_rst,
    input  logic [NUM_EVT*DATA_W-1:0] evt_i,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      mask_wr,
    input  logic [DATA_W-1:0]         mask_wdata,
    output logic                      irq_n
);

    localparam int IDX_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam int SUM_ADDR = 0;
    localparam int MSK_ADDR = 1;

    rd_src_e                        rd_src;
    logic [IDX_W-1:0]               rd_idx;
    logic [NUM_EVT-1:0]             evt_clr;
    logic [NUM_EVT-1:0][DATA_W-1:0] evt_q;
    logic [DATA_W-1:0]              summary;
    logic [DATA_W-1:0]              mask_q;

    evt_irq_dec #(
        .NUM_EVT (NUM_EVT),
        .ADDR_W  (ADDR_W),
        .EVT_BASE(EVT_BASE),
        .SUM_ADDR(SUM_ADDR),
        .MSK_ADDR(MSK_ADDR),
        .IDX_W   (IDX_W)
    ) u_dec (
        .rd_en_i(rd_en),
        .addr_i (rd_addr),
        .src_o  (rd_src),
        .idx_o  (rd_idx),
        .clr_o  (evt_clr)
    );

    // One sticky register per event group.
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        evt_irq_latch #(
            .DATA_W(DATA_W)
        ) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_rst_i(sw_rst),
            .clr_i   (evt_clr[k]),
            .set_i   (evt_i[k*DATA_W +: DATA_W]),
            .q_o     (evt_q[k])
        );
    end

    evt_irq_summary #(
        .NUM_EVT (NUM_EVT),
        .DATA_W  (DATA_W),
        .MASK_RST(MASK_RST)
    ) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst_i    (sw_rst),
        .mask_wr_i   (mask_wr),
        .mask_wdata_i(mask_wdata),
        .evt_q_i     (evt_q),
        .summary_o   (summary),
        .mask_q_o    (mask_q),
        .irq_n_o     (irq_n)
    );

    evt_irq_rdmux #(
        .NUM_EVT(NUM_EVT),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en),
        .src_i    (rd_src),
        .idx_i    (rd_idx),
        .evt_q_i  (evt_q),
        .summary_i(summary),
        .mask_i   (mask_q),
        .rd_data_o(rd_data)
    );

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Module: evt_irq_ctrl_chk
// Property checker for evt_irq_ctrl, attached by bind. It watches the
// ports together with the stored event registers and the mask.
// Assumes: the same parameter values as the bound instance.
module evt_irq_ctrl_chk #(
    parameter int                NUM_EVT  = 5,
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 8,
    parameter int                EVT_BASE = 2,
    parameter logic [DATA_W-1:0] MASK_RST = 8'hF8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sw_rst,
    input logic [NUM_EVT*DATA_W-1:0]      evt_i,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [DATA_W-1:0]              rd_data,
    input logic                           mask_wr,
    input logic [DATA_W-1:0]              mask_wdata,
    input logic                           irq_n,
    input logic [NUM_EVT-1:0][DATA_W-1:0] evt_q,
    input logic [DATA_W-1:0]              mask_q
);

    localparam int LOW_BITS = DATA_W - NUM_EVT;

    logic [DATA_W-1:0] sum_ref;

    // Summary rebuilt from the stored registers for the interrupt check.
    always_comb begin
        sum_ref = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            sum_ref[LOW_BITS+k] = |evt_q[k];
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (evt_q == '0 && mask_q == MASK_RST && irq_n)); // R1

    AST_SWRST_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (evt_q == '0 && mask_q == MASK_RST)); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !sw_rst) |=> (mask_q == $past(mask_wdata))); // R7

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(sum_ref & mask_q))); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R12

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_reg
        localparam logic [ADDR_W-1:0] RO_A  = ADDR_W'(EVT_BASE + 2*k);
        localparam logic [ADDR_W-1:0] COR_A = ADDR_W'(EVT_BASE + 2*k + 1);

        AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_rst && evt_i[k*DATA_W +: DATA_W] != '0) |=>
            ((evt_q[k] & $past(evt_i[k*DATA_W +: DATA_W])) ==
             $past(evt_i[k*DATA_W +: DATA_W]))); // R2

        AST_RO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == RO_A && !sw_rst) |=>
            ((evt_q[k] & $past(evt_q[k])) == $past(evt_q[k]))); // R3

        AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == COR_A && !sw_rst &&
             evt_i[k*DATA_W +: DATA_W] == '0) |=> (evt_q[k] == '0)); // R4

        AST_COR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == COR_A && !sw_rst) |=>
            (evt_q[k] == $past(evt_i[k*DATA_W +: DATA_W]))); // R5
    end

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .EVT_BASE(EVT_BASE),
    .MASK_RST(MASK_RST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .evt_i     (evt_i),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .mask_wr   (mask_wr),
    .mask_wdata(mask_wdata),
    .irq_n     (irq_n),
    .evt_q     (evt_q),
    .mask_q    (mask_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;

    localparam int NE = 5;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [1:0] OP_EV = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_MW = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] req;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] x;
        logic       irq;
    } vec_t;

    localparam int NV = 24;
    // op, requirement, address or register, data, expected read, expected irq_n
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RD, 4'd6,  8'h00, 8'h00, 8'h00, 1'b1}, // R6 empty summary
        '{OP_EV, 4'd2,  8'h02, 8'h05, 8'h00, 1'b0}, // R2 current limit bits
        '{OP_RD, 4'd3,  8'h06, 8'h00, 8'h05, 1'b0}, // R3 plain read
        '{OP_RD, 4'd6,  8'h00, 8'h00, 8'h20, 1'b0}, // R6 bit 5
        '{OP_RD, 4'd4,  8'h07, 8'h00, 8'h05, 1'b1}, // R4 clearing read
        '{OP_RD, 4'd4,  8'h06, 8'h00, 8'h00, 1'b1}, // R4 now empty
        '{OP_EV, 4'd10, 8'h04, 8'h81, 8'h00, 1'b0}, // R10 supply event
        '{OP_RD, 4'd6,  8'h00, 8'h00, 8'h80, 1'b0}, // R6 bit 7
        '{OP_RD, 4'd10, 8'h02, 8'h00, 8'h00, 1'b0}, // R10 power untouched
        '{OP_RD, 4'd10, 8'h04, 8'h00, 8'h00, 1'b0}, // R10 detect untouched
        '{OP_MW, 4'd8,  8'h00, 8'h7F, 8'h00, 1'b1}, // R8 bit 7 masked off
        '{OP_RD, 4'd7,  8'h01, 8'h00, 8'h7F, 1'b1}, // R7 mask readback
        '{OP_EV, 4'd8,  8'h01, 8'h10, 8'h00, 1'b0}, // R8 detect enabled
        '{OP_RD, 4'd6,  8'h00, 8'h00, 8'h90, 1'b0}, // R6 bits 7 and 4
        '{OP_RD, 4'd4,  8'h0B, 8'h00, 8'h81, 1'b0}, // R4 supply clear
        '{OP_RD, 4'd4,  8'h05, 8'h00, 8'h10, 1'b1}, // R4 detect clear
        '{OP_RD, 4'd6,  8'h00, 8'h00, 8'h00, 1'b1}, // R6 empty again
        '{OP_EV, 4'd2,  8'h00, 8'hFF, 8'h00, 1'b0}, // R2 power all bits
        '{OP_RD, 4'd4,  8'h03, 8'h00, 8'hFF, 1'b1}, // R4 power clear
        '{OP_EV, 4'd2,  8'h03, 8'h02, 8'h00, 1'b0}, // R2 startup bit
        '{OP_RD, 4'd11, 8'h0D, 8'h00, 8'h00, 1'b0}, // R11 odd unmapped
        '{OP_RD, 4'd11, 8'h09, 8'h00, 8'h02, 1'b1}, // R11 nothing lost
        '{OP_RD, 4'd11, 8'h0C, 8'h00, 8'h00, 1'b1}, // R11 even unmapped
        '{OP_MW, 4'd7,  8'h00, 8'hF8, 8'h00, 1'b1}  // R7 mask back
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_rst = 1'b0;
    logic [NE*DW-1:0]  evt = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic              mask_wr = 1'b0;
    logic [DW-1:0]     mask_wdata = '0;
    logic              irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl i_evt_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .evt_i     (evt),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .mask_wr   (mask_wr),
        .mask_wdata(mask_wdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic pulse_event(input int k, input logic [7:0] bits);
        @(negedge clk);
        evt = '0;
        evt[k*DW +: DW] = bits;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic mask_write(input logic [7:0] v);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        string      rq;

        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "rd_data after reset", rd_data, 8'h00);
        chk("R1", "irq_n after reset", {7'd0, irq_n}, 8'h01);
        do_read(8'h01, d);
        chk("R1", "mask default", d, 8'hF8);
        do_read(8'h0A, d);
        chk("R1", "supply register empty", d, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].op)
                OP_EV: pulse_event(int'(VECS[i].a), VECS[i].d);
                OP_RD: begin
                    do_read(VECS[i].a, d);
                    chk(rq, $sformatf("row %0d read %h", i, VECS[i].a), d, VECS[i].x);
                end
                default: mask_write(VECS[i].d);
            endcase
            chk(rq, $sformatf("row %0d irq_n", i), {7'd0, irq_n}, {7'd0, VECS[i].irq});
        end

        // R5: event in the same cycle as a clearing read of its register
        pulse_event(2, 8'h01);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 8'h07;
        evt[2*DW +: DW] = 8'h02;
        @(negedge clk);
        rd_en = 1'b0;
        evt = '0;
        chk("R5", "clearing read returns old bit only", rd_data, 8'h01);
        chk("R5", "irq_n held by new bit", {7'd0, irq_n}, 8'h00);
        do_read(8'h07, d);
        chk("R5", "new bit survived", d, 8'h02);

        // R12: read data holds while idle
        do_read(8'h01, held);
        pulse_event(0, 8'h01);
        repeat (3) @(negedge clk);
        chk("R12", "rd_data stable without strobe", rd_data, held);
        do_read(8'h03, d);
        chk("R12", "cleanup read", d, 8'h01);

        // R8: mask 0 blocks, mask change alone raises the interrupt
        mask_write(8'h00);
        pulse_event(3, 8'h04);
        chk("R8", "masked event leaves irq_n high", {7'd0, irq_n}, 8'h01);
        mask_write(8'h40);
        chk("R8", "enabling bit 6 drops irq_n", {7'd0, irq_n}, 8'h00);

        // R9: software reset with a coincident event and mask write
        pulse_event(1, 8'h20);
        @(negedge clk);
        sw_rst = 1'b1;
        evt[4*DW +: DW] = 8'h40;
        mask_wr = 1'b1;
        mask_wdata = 8'h11;
        @(negedge clk);
        sw_rst = 1'b0;
        evt = '0;
        mask_wr = 1'b0;
        chk("R9", "irq_n after software reset", {7'd0, irq_n}, 8'h01);
        for (int k = 0; k < NE; k++) begin
            do_read(8'(2 + 2*k), d);
            chk("R9", $sformatf("register %0d wiped", k), d, 8'h00);
        end
        do_read(8'h01, d);
        chk("R9", "mask restored", d, 8'hF8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule